// File: doc/BRIEF.md
# Scalable CAN Identifier Acceptance Filter

This block decides whether an incoming CAN frame header is wanted. The header gives an 11-bit base identifier, an 18-bit identifier extension, the IDE flag and the RTR flag. Up to `NUM_BANKS` filter banks (eight by default) examine the header at the same time. Each bank holds eight configuration bytes and one control byte. The control byte marks the bank active or idle. It also selects how the eight bytes are split into filters: one wide filter, two medium filters, four narrow filters, or one medium plus two narrow. It also selects whether each pair of fields means identifier plus mask, or two separate identifiers that must match exactly.

A header is presented with a one-cycle strobe. On the next cycle the block reports whether some filter accepted it, and the number of the lowest accepting filter. A frame with no accepting filter is simply reported as rejected, so the receiver can drop it without software help. Configuration is loaded through a byte-wide write port.

Top module: `can_id_filter`

## Requirements
- R1: After a synchronous active-high reset, every configuration byte and control byte is zero, which leaves every bank idle. `res_valid`, `res_accept` and `res_index` are 0, and a header sent before any configuration is rejected.
- R2: A write with `cfg_addr` below 64 stores `cfg_wdata` in byte `cfg_addr[2:0]` of bank `cfg_addr[5:3]`. A write to address 64+b loads the control byte of bank b, with fields bit0 = active, bit1 = list mode, bits3:2 = scale.
- R3: A bank whose active bit is 0 never accepts a header, whatever its bytes hold.
- R4: Scale 3 (wide) forms the 32-bit key {base[10:0], ext[17:0], IDE, RTR, 0}. Bit 0 of the key is never compared. Bytes 0-3 give the first word, with byte 0 most significant, and bytes 4-7 give the second word. Mask mode uses filter slot 0. List mode uses slot 0 for the first word and slot 1 for the second.
- R5: Scale 1 (medium) forms the 16-bit key {base[10:0], RTR, IDE, 000}, and bits 2:0 are never compared. Medium element j is taken from bytes {2j, 2j+1} in the first half and from {4+2j, 5+2j} in the second half. Mask mode puts element j in slot j. List mode puts the first-half element in slot 2j and the second-half element in slot 2j+1.
- R6: Scale 0 (narrow) forms the 8-bit key base[10:3]. No other header bit takes part. Narrow element j is byte j in the first half and byte j+4 in the second half. Mask mode puts element j in slot j. List mode puts the first-half element in slot 2j and the second-half element in slot 2j+1.
- R7: Scale 2 (mixed) uses medium element 0 (bytes 0,1 / 4,5) and narrow elements 2 and 3 (bytes 2 / 6 and 3 / 7). Their slots follow the R5 and R6 numbering: 0, 2 and 3 in mask mode, and 0, 1, 4, 5, 6 and 7 in list mode.
- R8: In mask mode, the second-half field is a mask. A key bit whose mask bit is 1 must equal the first-half identifier bit, and a key bit whose mask bit is 0 is ignored.
- R9: In list mode, each half is an identifier of its own, and every compared key bit must equal it exactly.
- R10: Filter number b*8+slot identifies a filter. When several filters accept, the lowest number is reported. When none accept, `res_accept` is 0 and `res_index` is 0.
- R11: `res_valid` rises exactly one cycle after `hdr_valid` and lasts one cycle. The decision uses the configuration held before any configuration write made in the same cycle as the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| hdr_valid | input | 1 | Header strobe, one cycle per header |
| hdr_std_id | input | 11 | Base identifier |
| hdr_ext_id | input | 18 | Identifier extension |
| hdr_ide | input | 1 | Extended-format flag |
| hdr_rtr | input | 1 | Remote-request flag |
| res_valid | output | 1 | Decision valid |
| res_accept | output | 1 | Header accepted |
| res_index | output | 6 | Lowest accepting filter number |

## Verification
A configuration write and a header evaluation can land in the same cycle. The bench provokes this by issuing, on the cycle of a header strobe, a control write that turns an idle bank into one that accepts every header. The reported decision must follow the old configuration, and the next header must follow the new one. The main body sweeps every base identifier through each of the eight scale/mode pairs and compares each result with a model built from the slot numbering rules.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  localparam int BYTE_W      = 8;
  localparam int BANK_BYTES  = 8;
  localparam int BANK_BITS   = BYTE_W * BANK_BYTES;
  localparam int BANK_SLOTS  = 8;
  localparam int STD_W       = 11;
  localparam int EXT_W       = 18;

  // Bits of the wide and medium keys that carry header content.
  localparam logic [31:0] COVER32 = 32'hFFFF_FFFE;
  localparam logic [15:0] COVER16 = 16'hFFF8;

  typedef enum logic [1:0] {
    SC_QUAD8    = 2'b00,
    SC_DUAL16   = 2'b01,
    SC_MIXED    = 2'b10,
    SC_SINGLE32 = 2'b11
  } scale_e;

  // Packed so that it lines up with control byte bits [3:0].
  typedef struct packed {
    scale_e scale;
    logic   list;
    logic   active;
  } bank_ctl_t;

  typedef struct packed {
    logic [31:0] k32;
    logic [15:0] k16;
    logic [7:0]  k8;
  } keys_t;

  function automatic keys_t build_keys(input logic [STD_W-1:0] std_id,
                                       input logic [EXT_W-1:0] ext_id,
                                       input logic ide, input logic rtr);
    keys_t k;
    k.k32 = {std_id, ext_id, ide, rtr, 1'b0};
    k.k16 = {std_id, rtr, ide, 3'b000};
    k.k8  = std_id[STD_W-1:STD_W-8];
    return k;
  endfunction

endpackage

// File: rtl/can_filt_cfg.sv
module can_filt_cfg
  import can_filt_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_AW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CFG_AW   = BANK_AW + 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [BYTE_W-1:0]             cfg_wdata,
  output logic [NUM_BANKS*BANK_BITS-1:0] bank_bytes,
  output bank_ctl_t [NUM_BANKS-1:0]     bank_ctl
);

  localparam int NUM_BYTES = NUM_BANKS * BANK_BYTES;

  logic [BYTE_W-1:0]   mem [NUM_BYTES];
  bank_ctl_t [NUM_BANKS-1:0] ctl_q;

  logic                 sel_ctl;
  logic [BANK_AW+2:0]   byte_idx;
  logic [BANK_AW-1:0]   ctl_idx;
  logic                 byte_ok;
  logic                 ctl_ok;

  assign sel_ctl  = cfg_addr[CFG_AW-1];
  assign byte_idx = cfg_addr[BANK_AW+2:0];
  assign ctl_idx  = cfg_addr[BANK_AW-1:0];
  assign byte_ok  = (32'(byte_idx) < NUM_BYTES);
  assign ctl_ok   = (cfg_addr[CFG_AW-2:BANK_AW] == '0) && (32'(ctl_idx) < NUM_BANKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BYTES; i++) mem[i] <= '0;
      ctl_q <= '0;
    end else if (cfg_we) begin
      if (!sel_ctl) begin
        if (byte_ok) mem[byte_idx] <= cfg_wdata;
      end else if (ctl_ok) begin
        ctl_q[ctl_idx] <= bank_ctl_t'(cfg_wdata[3:0]);
      end
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_flat
    assign bank_bytes[g*BYTE_W +: BYTE_W] = mem[g];
  end
  assign bank_ctl = ctl_q;

  // R2: a byte write is visible on the next cycle
  a_r2_byte_lands: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !sel_ctl && byte_ok) |=> (mem[$past(byte_idx)] == $past(cfg_wdata)));

  // R2: a control write is visible on the next cycle
  a_r2_ctl_lands: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && sel_ctl && ctl_ok) |=> (ctl_q[$past(ctl_idx)] == bank_ctl_t'($past(cfg_wdata[3:0]))));

endmodule

// File: rtl/can_filt_bank.sv
module can_filt_bank
  import can_filt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BANK_BITS-1:0]  bytes,
  input  bank_ctl_t             ctl,
  input  keys_t                 keys,
  output logic [BANK_SLOTS-1:0] hit
);

  localparam int N8  = BANK_BYTES / 2;
  localparam int N16 = BANK_BYTES / 4;

  logic [BYTE_W-1:0] r [BANK_BYTES];
  for (genvar i = 0; i < BANK_BYTES; i++) begin : g_bytes
    assign r[i] = bytes[i*BYTE_W +: BYTE_W];
  end

  // Narrow elements: byte j (first half) and byte j+4 (second half).
  logic [N8-1:0] eq8a, eq8b, mk8;
  for (genvar j = 0; j < N8; j++) begin : g_e8
    assign eq8a[j] = (keys.k8 == r[j]);
    assign eq8b[j] = (keys.k8 == r[j+N8]);
    assign mk8[j]  = (((keys.k8 ^ r[j]) & r[j+N8]) == '0);
  end

  // Medium elements: bytes {2j,2j+1} and {4+2j,5+2j}.
  logic [N16-1:0] eq16a, eq16b, mk16;
  for (genvar j = 0; j < N16; j++) begin : g_e16
    logic [15:0] ida, idb;
    assign ida      = {r[2*j], r[2*j+1]};
    assign idb      = {r[N8+2*j], r[N8+2*j+1]};
    assign eq16a[j] = (((keys.k16 ^ ida) & COVER16) == '0);
    assign eq16b[j] = (((keys.k16 ^ idb) & COVER16) == '0);
    assign mk16[j]  = (((keys.k16 ^ ida) & idb & COVER16) == '0);
  end

  // Wide element: bytes 0..3 and 4..7, lowest byte number most significant.
  logic [31:0] w32a, w32b;
  logic        eq32a, eq32b, mk32;
  assign w32a  = {r[0], r[1], r[2], r[3]};
  assign w32b  = {r[4], r[5], r[6], r[7]};
  assign eq32a = (((keys.k32 ^ w32a) & COVER32) == '0);
  assign eq32b = (((keys.k32 ^ w32b) & COVER32) == '0);
  assign mk32  = (((keys.k32 ^ w32a) & w32b & COVER32) == '0);

  always_comb begin
    hit = '0;
    if (ctl.active) begin
      unique case (ctl.scale)
        SC_QUAD8: begin
          for (int j = 0; j < N8; j++) begin
            if (ctl.list) begin
              hit[2*j]   = eq8a[j];
              hit[2*j+1] = eq8b[j];
            end else begin
              hit[j] = mk8[j];
            end
          end
        end
        SC_DUAL16: begin
          for (int j = 0; j < N16; j++) begin
            if (ctl.list) begin
              hit[2*j]   = eq16a[j];
              hit[2*j+1] = eq16b[j];
            end else begin
              hit[j] = mk16[j];
            end
          end
        end
        SC_MIXED: begin
          if (ctl.list) begin
            hit[0] = eq16a[0];
            hit[1] = eq16b[0];
            for (int j = 2; j < N8; j++) begin
              hit[2*j]   = eq8a[j];
              hit[2*j+1] = eq8b[j];
            end
          end else begin
            hit[0] = mk16[0];
            for (int j = 2; j < N8; j++) hit[j] = mk8[j];
          end
        end
        SC_SINGLE32: begin
          if (ctl.list) begin
            hit[0] = eq32a;
            hit[1] = eq32b;
          end else begin
            hit[0] = mk32;
          end
        end
        default: hit = '0;
      endcase
    end
  end

  // R4: wide scale never raises slots above 1, and slot 1 only in list mode
  a_r4_wide_slots: assert property (@(posedge clk) disable iff (rst)
    (ctl.active && ctl.scale == SC_SINGLE32) |-> (hit[7:2] == '0 && (ctl.list || !hit[1])));

  // R8: mask mode uses at most slots 0..3
  a_r8_mask_slots: assert property (@(posedge clk) disable iff (rst)
    (ctl.active && !ctl.list) |-> (hit[7:4] == '0));

  // R7: mixed mask mode leaves slot 1 empty
  a_r7_mixed_gap: assert property (@(posedge clk) disable iff (rst)
    (ctl.active && !ctl.list && ctl.scale == SC_MIXED) |-> !hit[1]);

  // R9: two equal narrow list identifiers give equal slot results
  a_r9_list_twins: assert property (@(posedge clk) disable iff (rst)
    (ctl.active && ctl.list && ctl.scale == SC_QUAD8 && r[0] == r[4]) |-> (hit[0] == hit[1]));

endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
  parameter int WIDTH = 64,
  localparam int IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] vec,
  output logic             any,
  output logic [IW-1:0]    idx
);

  always_comb begin
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;

  // R10: the reported filter accepts and no lower filter does
  a_r10_lowest: assert property (@(posedge clk) disable iff (rst)
    any |-> (vec[idx] && ((vec & ((WIDTH'(1) << idx) - WIDTH'(1))) == '0)));

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_filt_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_AW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CFG_AW   = BANK_AW + 4,
  localparam int NFILT    = NUM_BANKS * BANK_SLOTS,
  localparam int IDX_W    = $clog2(NFILT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              hdr_valid,
  input  logic [10:0]       hdr_std_id,
  input  logic [17:0]       hdr_ext_id,
  input  logic              hdr_ide,
  input  logic              hdr_rtr,
  output logic              res_valid,
  output logic              res_accept,
  output logic [IDX_W-1:0]  res_index
);

  logic [NUM_BANKS*BANK_BITS-1:0] bank_bytes;
  bank_ctl_t [NUM_BANKS-1:0]      bank_ctl;
  keys_t                          keys;
  logic [NFILT-1:0]               all_hits;
  logic                           any_hit;
  logic [IDX_W-1:0]               first_hit;

  can_filt_cfg #(.NUM_BANKS(NUM_BANKS)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .bank_bytes(bank_bytes),
    .bank_ctl  (bank_ctl)
  );

  assign keys = build_keys(hdr_std_id, hdr_ext_id, hdr_ide, hdr_rtr);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    can_filt_bank u_bank (
      .clk  (clk),
      .rst  (rst),
      .bytes(bank_bytes[b*BANK_BITS +: BANK_BITS]),
      .ctl  (bank_ctl[b]),
      .keys (keys),
      .hit  (all_hits[b*BANK_SLOTS +: BANK_SLOTS])
    );
  end

  can_filt_prio #(.WIDTH(NFILT)) u_prio (
    .clk (clk),
    .rst (rst),
    .vec (all_hits),
    .any (any_hit),
    .idx (first_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_index  <= '0;
    end else begin
      res_valid  <= hdr_valid;
      res_accept <= hdr_valid && any_hit;
      res_index  <= (hdr_valid && any_hit) ? first_hit : '0;
    end
  end

  // R11: every strobe yields a decision one cycle later
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> res_valid);

  // R11: no strobe, no decision
  a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> (!res_valid && !res_accept));

  // R10: rejection reports filter number zero
  a_r10_reject_index: assert property (@(posedge clk) disable iff (rst)
    !res_accept |-> (res_index == '0));

endmodule

// File: tb/test_can_id_filter.sv
module test_can_id_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       hdr_valid = 1'b0;
  logic [10:0] hdr_std_id = '0;
  logic [17:0] hdr_ext_id = '0;
  logic       hdr_ide = 1'b0;
  logic       hdr_rtr = 1'b0;
  logic       res_valid, res_accept;
  logic [5:0] res_index;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_id_filter i_can_id_filter (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hdr_valid(hdr_valid), .hdr_std_id(hdr_std_id), .hdr_ext_id(hdr_ext_id),
    .hdr_ide(hdr_ide), .hdr_rtr(hdr_rtr),
    .res_valid(res_valid), .res_accept(res_accept), .res_index(res_index)
  );

  logic [7:0] sh_reg [NB*8];
  logic       sh_act [NB];
  logic       sh_list[NB];
  logic [1:0] sh_scale[NB];
  int checks = 0;
  int fails = 0;
  logic [31:0] seed = 32'h1357_9BDF;

  function automatic logic [31:0] nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Compare the covered bits of a key against an identifier under a mask.
  function automatic bit fmatch(input int width, input logic [31:0] id,
                                input logic [31:0] msk, input logic [31:0] key);
    for (int i = 0; i < width; i++) begin
      bit covered;
      covered = (width == 32) ? (i != 0) : (width == 16) ? (i >= 3) : 1'b1;
      if (covered && msk[i] && (id[i] != key[i])) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [7:0] bank_ref(input int b, input logic [31:0] k32,
                                          input logic [31:0] k16, input logic [31:0] k8);
    logic [7:0] h;
    logic [7:0] r [8];
    h = '0;
    for (int i = 0; i < 8; i++) r[i] = sh_reg[b*8+i];
    if (!sh_act[b]) return '0;
    case (sh_scale[b])
      2'd3: begin
        if (sh_list[b]) begin
          h[0] = fmatch(32, {r[0], r[1], r[2], r[3]}, '1, k32);
          h[1] = fmatch(32, {r[4], r[5], r[6], r[7]}, '1, k32);
        end else begin
          h[0] = fmatch(32, {r[0], r[1], r[2], r[3]}, {r[4], r[5], r[6], r[7]}, k32);
        end
      end
      2'd1: begin
        for (int j = 0; j < 2; j++) begin
          if (sh_list[b]) begin
            h[2*j]   = fmatch(16, {16'h0, r[2*j], r[2*j+1]}, '1, k16);
            h[2*j+1] = fmatch(16, {16'h0, r[4+2*j], r[5+2*j]}, '1, k16);
          end else begin
            h[j] = fmatch(16, {16'h0, r[2*j], r[2*j+1]}, {16'h0, r[4+2*j], r[5+2*j]}, k16);
          end
        end
      end
      2'd0: begin
        for (int j = 0; j < 4; j++) begin
          if (sh_list[b]) begin
            h[2*j]   = fmatch(8, {24'h0, r[j]}, '1, k8);
            h[2*j+1] = fmatch(8, {24'h0, r[j+4]}, '1, k8);
          end else begin
            h[j] = fmatch(8, {24'h0, r[j]}, {24'h0, r[j+4]}, k8);
          end
        end
      end
      default: begin
        if (sh_list[b]) begin
          h[0] = fmatch(16, {16'h0, r[0], r[1]}, '1, k16);
          h[1] = fmatch(16, {16'h0, r[4], r[5]}, '1, k16);
          for (int j = 2; j < 4; j++) begin
            h[2*j]   = fmatch(8, {24'h0, r[j]}, '1, k8);
            h[2*j+1] = fmatch(8, {24'h0, r[j+4]}, '1, k8);
          end
        end else begin
          h[0] = fmatch(16, {16'h0, r[0], r[1]}, {16'h0, r[4], r[5]}, k16);
          for (int j = 2; j < 4; j++) h[j] = fmatch(8, {24'h0, r[j]}, {24'h0, r[j+4]}, k8);
        end
      end
    endcase
    return h;
  endfunction

  function automatic void model(input logic [10:0] s, input logic [17:0] e,
                                input logic i, input logic r,
                                output bit acc, output logic [5:0] idx);
    logic [31:0] k32, k16, k8;
    k32 = (32'(s) << 21) | (32'(e) << 3) | (32'(i) << 2) | (32'(r) << 1);
    k16 = (32'(s) << 5) | (32'(r) << 4) | (32'(i) << 3);
    k8  = 32'(s) >> 3;
    acc = 1'b0;
    idx = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      logic [7:0] h;
      h = bank_ref(b, k32, k16, k8);
      for (int sl = 7; sl >= 0; sl--) begin
        if (h[sl]) begin
          acc = 1'b1;
          idx = 6'(b*8 + sl);
        end
      end
    end
  endfunction

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 7'd64) sh_reg[a] = d;
    else if (a < 7'd72) begin
      sh_act[a[2:0]] = d[0]; sh_list[a[2:0]] = d[1]; sh_scale[a[2:0]] = d[3:2];
    end
  endtask

  task automatic send_check(input logic [10:0] s, input logic [17:0] e,
                            input logic i, input logic r, input string tag);
    bit acc;
    logic [5:0] idx;
    model(s, e, i, r, acc, idx);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_std_id = s; hdr_ext_id = e; hdr_ide = i; hdr_rtr = r;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk(res_valid && res_accept == acc && res_index == idx, tag,
        $sformatf("hdr std=%0h ext=%0h ide=%0b rtr=%0b {valid,accept,index}", s, e, i, r),
        {24'h0, res_valid, res_accept, res_index}, {24'h0, 1'b1, acc, idx});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < NB*8; k++) sh_reg[k] = '0;
    for (int b = 0; b < NB; b++) begin sh_act[b] = 0; sh_list[b] = 0; sh_scale[b] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state of outputs
    chk(res_valid == 1'b0, "R1", "res_valid after reset", 32'(res_valid), 0);
    chk(res_accept == 1'b0, "R1", "res_accept after reset", 32'(res_accept), 0);
    chk(res_index == 6'd0, "R1", "res_index after reset", 32'(res_index), 0);
    send_check(11'h123, 18'h0, 1'b0, 1'b0, "R1 unconfigured reject");
    chk(res_accept == 1'b0, "R1", "unconfigured header accepted", 32'(res_accept), 0);

    // Sweep every base identifier through each scale/mode pair on bank 2.
    for (int combo = 0; combo < 8; combo++) begin
      logic [1:0] sc;
      bit ls;
      string tag;
      sc = 2'(combo >> 1);
      ls = combo[0];
      case (sc)
        2'd3: tag = ls ? "R4/R9" : "R4/R8";
        2'd1: tag = ls ? "R5/R9" : "R5/R8";
        2'd0: tag = ls ? "R6/R9" : "R6/R8";
        default: tag = ls ? "R7/R9" : "R7/R8";
      endcase
      for (int k = 0; k < 8; k++) wr(7'(16 + k), nxt()[7:0]);
      wr(7'd66, {4'h0, sc, ls, 1'b1});
      for (int s = 0; s < 2048; s++) begin
        logic [31:0] rv, w;
        logic [17:0] e;
        logic i, r;
        rv = nxt();
        w = rv[0] ? {sh_reg[16], sh_reg[17], sh_reg[18], sh_reg[19]}
                  : {sh_reg[20], sh_reg[21], sh_reg[22], sh_reg[23]};
        e = rv[1] ? w[20:3] : rv[29:12];
        i = rv[2] ? w[2] : rv[5];
        r = rv[3] ? w[1] : rv[6];
        send_check(11'(s), e, i, r, tag);
      end
      wr(7'd66, 8'h00);
    end

    // R3: idle bank 0 set to accept everything must stay silent.
    for (int k = 0; k < 8; k++) wr(7'(k), 8'h00);
    wr(7'd64, 8'h00);
    send_check(11'h7FF, 18'h3FFFF, 1'b1, 1'b1, "R3 idle bank");
    chk(res_accept == 1'b0, "R3", "idle bank accepted", 32'(res_accept), 0);

    // R11: control write in the strobe cycle is not seen by that header.
    @(negedge clk);
    hdr_valid = 1'b1; hdr_std_id = 11'h055; hdr_ext_id = 18'h1; hdr_ide = 0; hdr_rtr = 0;
    cfg_we = 1'b1; cfg_addr = 7'd64; cfg_wdata = 8'h01;
    @(negedge clk);
    hdr_valid = 1'b0; cfg_we = 1'b0;
    chk(res_valid && !res_accept, "R11", "same-cycle write seen early {valid,accept}",
        {30'h0, res_valid, res_accept}, 32'h2);
    sh_act[0] = 1'b1;
    send_check(11'h055, 18'h1, 1'b0, 1'b0, "R11 new config");
    chk(res_accept && res_index == 6'd0, "R11", "new config {accept,index}",
        {25'h0, res_accept, res_index}, 32'h40);
    wr(7'd64, 8'h00);

    // R2/R10: all banks active with random setups, priority across banks.
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < 4; k++) wr(7'(b*8 + k), nxt()[7:0]);
      for (int k = 4; k < 8; k++) begin
        logic [31:0] a, c;
        a = nxt(); c = nxt();
        wr(7'(b*8 + k), a[7:0] & c[7:0]);
      end
      wr(7'(64 + b), {4'h0, nxt()[3:1], 1'b1});
    end
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rv, w;
      int b;
      rv = nxt();
      b = int'(rv[10:8]);
      w = {sh_reg[b*8], sh_reg[b*8+1], sh_reg[b*8+2], sh_reg[b*8+3]};
      if (rv[0]) send_check(w[31:21], w[20:3], w[2], w[1], "R2/R10 priority");
      else send_check(rv[31:21], rv[28:11], rv[4], rv[5], "R2/R10 priority");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule